// File: doc/BRIEF.md
# Twelve-Bit Reload Timer

This block is a free-running 12-bit up-counter that sits on an 8-bit register bus. It advances once per tick. The tick comes either from a slow timebase pulse supplied from outside, or from every cycle of the block clock. When the count steps past its all-ones value, the counter restarts from a programmable reload value instead of from zero, and it raises an overflow flag.

A 12-bit compare value raises a second flag when the counter matches it on a tick. Each flag has its own enable, which gates it onto a single level-sensitive interrupt line.

Software reads a status register to see the flags and to acknowledge them. The same read clears both flags. The count is read as two byte registers, so the high byte may move between the two reads. The clock source field can also stop the counter.

Top module: `reload_timer12`

## Requirements
- R1: After reset every register reads 00h, the count is zero and irq_o is low.
- R2: With clock select 01 the count rises by one on each clock edge where ms_tick_i is high and holds otherwise. With clock select 10 it rises by one on every clock edge.
- R3: With clock select 00 or the reserved code 11 the count holds, whatever ms_tick_i does.
- R4: A tick taken while the count is FFFh loads the reload value into the counter and sets the overflow flag, which is status bit 2.
- R5: A read of the status register (address 0) clears the overflow flag and the compare flag after the read. If a flag-setting event falls in the same cycle as that read, the flag stays set.
- R6: A tick taken while the count equals the compare value sets the compare flag, which reads as bit 7 of the compare high register (address 5). Reading address 5 does not clear the flag.
- R7: irq_o is high exactly when (overflow flag AND status bit 1) OR (compare flag AND status bit 0).
- R8: The status register holds the clock select in bits 4:3, the overflow enable in bit 1 and the compare enable in bit 0. Bits 7:5 read zero. Writes to bit 2 and to bits 7:5 have no effect.
- R9: Address 1 reads {0000, count[11:8]} and address 2 reads count[7:0]. Writes to either address are ignored.
- R10: The reload value is written at addresses 3 (high, low nibble used) and 4 (low byte), and the compare value at addresses 5 and 6 in the same way. Each reads back with bits 6:4 of the high byte at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe; status side effects follow it |
| rdata_o | output | 8 | Read data, valid while rd_i is high, zero otherwise |
| ms_tick_i | input | 1 | Slow timebase pulse, one cycle wide |
| irq_o | output | 1 | Level interrupt request |

## Verification
Three events can coincide: the status read that acknowledges the flags, the tick that wraps the counter from FFFh, and the compare match. The bench parks the counter at FFFh with the compare value also at FFFh. It then issues the status read in the same cycle as the slow tick. The read must return the old flags, and both flags must still be set afterwards, with the counter at the reload value. A second status read must then clear both flags.

// File: rtl/rt12_pkg.sv
package rt12_pkg;
  typedef enum logic [1:0] {
    CS_OFF = 2'b00,
    CS_MS  = 2'b01,
    CS_CPU = 2'b10,
    CS_RSV = 2'b11
  } clk_sel_e;

  // register addresses; split registers use base + 2*index
  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_CNT_HI = 1;
  localparam int unsigned ADDR_CNT_LO = 2;
  localparam int unsigned ADDR_RLD_HI = 3;
  localparam int unsigned ADDR_RLD_LO = 4;
  localparam int unsigned ADDR_CMP_HI = 5;
  localparam int unsigned ADDR_CMP_LO = 6;

  // status bit positions
  localparam int unsigned CS_LSB    = 3;
  localparam int unsigned OVF_BIT   = 2;
  localparam int unsigned OVFIE_BIT = 1;
  localparam int unsigned CMPIE_BIT = 0;
  localparam int unsigned CMPF_BIT  = 7;
endpackage

// File: rtl/rt12_tick_gate.sv
module rt12_tick_gate
  import rt12_pkg::*;
(
  input  clk_sel_e sel_i,
  input  logic     ms_tick_i,
  output logic     tick_o
);
  always_comb begin
    unique case (sel_i)
      CS_MS:   tick_o = ms_tick_i;
      CS_CPU:  tick_o = 1'b1;
      default: tick_o = 1'b0;  // off and reserved both stop
    endcase
  end
endmodule

// File: rtl/rt12_core.sv
module rt12_core #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             cmpf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic ovf_q, cmpf_q, wrap, hit;

  assign wrap = tick_i && (cnt_q == {CNT_W{1'b1}});
  assign hit  = tick_i && (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) cnt_q <= wrap ? reload_i : cnt_q + 1'b1;
  end

  // set beats clear so an event coinciding with the acknowledging read survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      cmpf_q <= 1'b0;
    end else begin
      if (wrap) ovf_q <= 1'b1;
      else if (clr_i) ovf_q <= 1'b0;
      if (hit) cmpf_q <= 1'b1;
      else if (clr_i) cmpf_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;
  assign cmpf_o = cmpf_q;

  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == $past(reload_i)));
  p_ovf_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == {CNT_W{1'b1}}) |=> ovf_q);
  p_cmp_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == cmp_i) |=> cmpf_q);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/rt12_bus.sv
module rt12_bus
  import rt12_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output clk_sel_e          sel_o,
  output logic              ovf_ie_o,
  output logic              cmp_ie_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              stat_rd_o,
  input  logic              ovf_i,
  input  logic              cmpf_i,
  input  logic [CNT_W-1:0]  cnt_i
);
  localparam int unsigned HI_W  = CNT_W - DATA_W;
  localparam int unsigned N_SPL = 2;  // reload, compare

  logic [1:0] sel_q;
  logic ovf_ie_q, cmp_ie_q, ctrl_we;
  logic [CNT_W-1:0] split_q [N_SPL];

  assign ctrl_we = wr_i && (addr_i == ADDR_W'(ADDR_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      ovf_ie_q <= 1'b0;
      cmp_ie_q <= 1'b0;
    end else if (ctrl_we) begin
      sel_q    <= wdata_i[CS_LSB+1:CS_LSB];
      ovf_ie_q <= wdata_i[OVFIE_BIT];
      cmp_ie_q <= wdata_i[CMPIE_BIT];
    end
  end

  for (genvar g = 0; g < N_SPL; g++) begin : g_split
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_i) begin
        if (addr_i == ADDR_W'(ADDR_RLD_HI + 2*g)) q[CNT_W-1:DATA_W] <= wdata_i[HI_W-1:0];
        if (addr_i == ADDR_W'(ADDR_RLD_LO + 2*g)) q[DATA_W-1:0]     <= wdata_i;
      end
    end
    assign split_q[g] = q;
  end

  assign reload_o  = split_q[0];
  assign cmp_o     = split_q[1];
  assign sel_o     = clk_sel_e'(sel_q);
  assign ovf_ie_o  = ovf_ie_q;
  assign cmp_ie_o  = cmp_ie_q;
  assign stat_rd_o = rd_i && (addr_i == ADDR_W'(ADDR_CTRL));

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        ADDR_W'(ADDR_CTRL): begin
          rdata_o[CS_LSB+1:CS_LSB] = sel_q;
          rdata_o[OVF_BIT]         = ovf_i;
          rdata_o[OVFIE_BIT]       = ovf_ie_q;
          rdata_o[CMPIE_BIT]       = cmp_ie_q;
        end
        ADDR_W'(ADDR_CNT_HI): rdata_o[HI_W-1:0] = cnt_i[CNT_W-1:DATA_W];
        ADDR_W'(ADDR_CNT_LO): rdata_o = cnt_i[DATA_W-1:0];
        ADDR_W'(ADDR_RLD_HI): rdata_o[HI_W-1:0] = split_q[0][CNT_W-1:DATA_W];
        ADDR_W'(ADDR_RLD_LO): rdata_o = split_q[0][DATA_W-1:0];
        ADDR_W'(ADDR_CMP_HI): begin
          rdata_o[HI_W-1:0] = split_q[1][CNT_W-1:DATA_W];
          rdata_o[CMPF_BIT] = cmpf_i;
        end
        ADDR_W'(ADDR_CMP_LO): rdata_o = split_q[1][DATA_W-1:0];
        default: rdata_o = '0;
      endcase
    end
  end

  p_ctrl_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we |=> (sel_q == $past(wdata_i[CS_LSB+1:CS_LSB])));
  p_ctrl_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> $stable(sel_q) && $stable(ovf_ie_q) && $stable(cmp_ie_q));
endmodule

// File: rtl/reload_timer12.sv
module reload_timer12
  import rt12_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ms_tick_i,
  output logic              irq_o
);
  clk_sel_e sel;
  logic ovf_ie, cmp_ie, stat_rd, tick, ovf, cmpf;
  logic [CNT_W-1:0] reload, cmp_val, cnt;

  rt12_bus #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_bus (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i, .rd_i, .rdata_o,
    .sel_o(sel), .ovf_ie_o(ovf_ie), .cmp_ie_o(cmp_ie),
    .reload_o(reload), .cmp_o(cmp_val), .stat_rd_o(stat_rd),
    .ovf_i(ovf), .cmpf_i(cmpf), .cnt_i(cnt)
  );

  rt12_tick_gate u_gate (.sel_i(sel), .ms_tick_i, .tick_o(tick));

  rt12_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .tick_i(tick), .reload_i(reload), .cmp_i(cmp_val),
    .clr_i(stat_rd), .cnt_o(cnt), .ovf_o(ovf), .cmpf_o(cmpf)
  );

  assign irq_o = (ovf & ovf_ie) | (cmpf & cmp_ie);

  p_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == CS_OFF || sel == CS_RSV) |=> $stable(cnt));
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !(tick && cnt == {CNT_W{1'b1}})) |=> !ovf);
  p_irq_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (ovf || cmpf));
endmodule

// File: tb/reload_timer12_bench.sv
module reload_timer12_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic wr = 1'b0, rd = 1'b0, ms_tick = 1'b0, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reload_timer12 u_reload_timer12 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .rd_i(rd), .rdata_o(rdata), .ms_tick_i(ms_tick), .irq_o(irq)
  );

  // {addr, write data, expected readback}
  localparam logic [23:0] VEC [9] = '{
    {8'd0, 8'hFF, 8'h1B}, {8'd0, 8'h00, 8'h00}, {8'd3, 8'hAB, 8'h0B},
    {8'd4, 8'hCD, 8'hCD}, {8'd5, 8'hF7, 8'h07}, {8'd6, 8'h3C, 8'h3C},
    {8'd1, 8'h55, 8'h00}, {8'd2, 8'h66, 8'h00}, {8'd0, 8'hE6, 8'h02}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd_reg(3'(a), d); check("R1", d, 8'h00);
    end
    check("R1 irq", {7'd0, irq}, 8'h00);

    // table: R8 R9 R10 write/readback
    for (int i = 0; i < 9; i++) begin
      wr_reg(VEC[i][18:16], VEC[i][15:8]);
      rd_reg(VEC[i][18:16], d);
      check("R8/R9/R10 table", d, VEC[i][7:0]);
    end
    check("R7 no flags", {7'd0, irq}, 8'h00);

    // slow tick source, R2
    wr_reg(3'd6, 8'h05); wr_reg(3'd5, 8'h00);
    wr_reg(3'd0, 8'h0A);
    pulse(3);
    rd_reg(3'd2, d); check("R2 ms ticks", d, 8'h03);
    rd_reg(3'd1, d); check("R9 high byte", d, 8'h00);
    repeat (5) @(negedge clk);
    rd_reg(3'd2, d); check("R2 no tick hold", d, 8'h03);

    // R3 stopped codes
    wr_reg(3'd0, 8'h1A); pulse(2);
    rd_reg(3'd2, d); check("R3 reserved code", d, 8'h03);
    wr_reg(3'd0, 8'h02); pulse(2);
    rd_reg(3'd2, d); check("R3 off code", d, 8'h03);

    // R6 compare, R7 masking, R5 clear
    wr_reg(3'd0, 8'h0A); pulse(2);
    rd_reg(3'd5, d); check("R6 before match", d, 8'h00);
    pulse(1);
    rd_reg(3'd5, d); check("R6 match flag", d, 8'h80);
    check("R7 masked", {7'd0, irq}, 8'h00);
    wr_reg(3'd0, 8'h0B);
    check("R7 compare irq", {7'd0, irq}, 8'h01);
    rd_reg(3'd0, d); check("R8 status", d, 8'h0B);
    check("R5 irq cleared", {7'd0, irq}, 8'h00);
    rd_reg(3'd5, d); check("R5 cmpf cleared", d, 8'h00);

    // R4 overflow with every-clock source
    wr_reg(3'd0, 8'h12);
    for (int i = 0; i < 6000; i++) begin
      if (irq) break;
      @(negedge clk);
    end
    wr_reg(3'd0, 8'h02);  // one more count, then stopped
    rd_reg(3'd1, d); check("R4 reload high", d, 8'h0B);
    rd_reg(3'd2, d); check("R4 reload low", d, 8'hCE);
    rd_reg(3'd0, d); check("R4 ovf flag", d, 8'h06);
    check("R5 irq after read", {7'd0, irq}, 8'h00);
    rd_reg(3'd0, d); check("R5 ovf cleared", d, 8'h02);

    // R5 status read in the same cycle as wrap and compare match
    wr_reg(3'd5, 8'h0F); wr_reg(3'd6, 8'hFF);
    wr_reg(3'd0, 8'h0A);
    pulse(1073);
    rd_reg(3'd1, d); check("R9 top high", d, 8'h0F);
    rd_reg(3'd2, d); check("R9 top low", d, 8'hFF);
    addr = 3'd0; rd = 1'b1; ms_tick = 1'b1;
    #1 check("R8 read old flags", rdata, 8'h0A);
    @(negedge clk); rd = 1'b0; ms_tick = 1'b0;
    rd_reg(3'd5, d); check("R5 cmpf survives", d, 8'h8F);
    rd_reg(3'd0, d); check("R5 ovf survives", d, 8'h0E);
    rd_reg(3'd0, d); check("R5 cleared later", d, 8'h0A);
    rd_reg(3'd5, d); check("R5 cmpf cleared later", d, 8'h0F);
    rd_reg(3'd2, d); check("R4 wrap low", d, 8'hCD);
    rd_reg(3'd1, d); check("R4 wrap high", d, 8'h0B);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule